// File: doc/BRIEF.md
# Interrupt Redirection Delivery Engine

This block turns a set of interrupt request lines into delivery messages for a downstream interrupt fabric. Each pin owns a programmable redirection entry that decides how the line is read: inverted or not, edge or level sensitive, masked or not. The entry also fixes the destination, destination mode, delivery mode and vector that go into the message. A pending bit per pin records requests. When a pending, unmasked pin may be delivered, the engine emits one message at a time over a valid/ready handshake, and the lowest pin number goes first.

Level-sensitive pins lock after delivery through a remote-IRR flag held in the entry. An end-of-interrupt broadcast that carries a matching vector releases the lock. If the line is still active, the pin is delivered again. Pins whose delivery mode is the external-interrupt code (7) take their vector from an external legacy controller: the engine raises an acknowledge request and uses the vector that comes back. Entries are written 32 bits at a time through a simple write port, and a combinational read port returns the full 64-bit entry image.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset, every entry reads 64'h0000_0000_0001_0000 (only the mask bit 16 set), no pin is pending, and neither msgValid nor extAckReq is asserted.
- R2: Pin 2 is driven by the OR of lines 0 and 2. Pin 0 has no source and never becomes pending. Every other pin N is driven by line N.
- R3: Entry bit 13 set inverts the pin's line before any edge or level evaluation.
- R4: A level pin (bit 15 = 1) is pending exactly while its inverted-as-configured line is active, one cycle after the line changes.
- R5: An edge pin (bit 15 = 0) becomes pending on a 0-to-1 change of its configured line only if mask bit 16 is clear at that moment. A rise on a masked pin is dropped and does not cause a message after a later unmask.
- R6: When a message is accepted (msgValid and msgReady), an edge pin's pending bit clears. A level pin instead gets remote-IRR (bit 14) set and is not delivered again while that bit is set.
- R7: An EOI with vector V clears bit 14 on every entry that has bit 14 set and vector field V. If that pin is still pending and unmasked, it is delivered again.
- R8: A pin with delivery mode bits 10:8 = 7 first raises extAckReq and holds it until extAckDone. Its message then carries the vector sampled from extVector with extAckDone, not the entry's vector.
- R9: Among eligible pins, the lowest number is delivered first. Only one request (message or acknowledge) is outstanding at a time, and a message is held stable until accepted.
- R10: A write to an entry re-evaluates delivery: unmasking an already pending pin delivers it without any new line activity.
- R11: A message carries destination = bits 63:56, destination mode = bit 11, delivery mode = bits 10:8, vector = bits 7:0 and level flag = bit 15 of the pin's entry.
- R12: Bit 12 reads 1 for a pin while its acknowledge request or message is outstanding, and 0 otherwise.
- R13: A write with wrHigh = 0 loads bits 7:0, 10:8, 11, 13, 15 and 16 from wrData. A write with wrHigh = 1 loads bits 63:56 from wrData[31:24]. Bits 12 and 14 and all other bits cannot be written, and those other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_PINS | Raw interrupt request lines |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | IDX_W | Entry index for write |
| wrHigh | input | 1 | 1 selects upper 32 bits, 0 lower |
| wrData | input | 32 | Write data |
| rdIdx | input | IDX_W | Entry index for read |
| rdData | output | 64 | Entry image, including remote-IRR and delivery status |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | 8 | Vector carried by the EOI |
| msgValid | output | 1 | Delivery message valid |
| msgReady | input | 1 | Downstream accepts the message |
| msgDest | output | 8 | Message destination |
| msgDestMode | output | 1 | Message destination mode |
| msgDelivMode | output | 3 | Message delivery mode |
| msgVector | output | 8 | Message vector |
| msgLevel | output | 1 | Message trigger mode (1 = level) |
| extAckReq | output | 1 | Vector fetch request to the legacy controller |
| extAckDone | input | 1 | Legacy controller returns a vector |
| extVector | input | 8 | Vector from the legacy controller |

## Verification
A corrupted pending bit shows within two cycles as a message that should not appear, or as one that is missing. A remote-IRR flag left set by mistake shows only later, when an EOI fails to bring back a still-active level pin. A flag that clears too early shows as a duplicate message on the very next free cycle. A wrong captured index or latched trigger mode stays hidden until acceptance, and then shows up as the wrong pin being cleared or locked. So the bench models each cycle and compares message fields and the acknowledge request on every clock, and checks the entry image through the read port after each scenario.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam int VEC_LSB      = 0;
  localparam int DM_LSB       = 8;
  localparam int DESTMODE_BIT = 11;
  localparam int DSTAT_BIT    = 12;
  localparam int POL_BIT      = 13;
  localparam int RIRR_BIT     = 14;
  localparam int TRIG_BIT     = 15;
  localparam int MASK_BIT     = 16;
  localparam int DEST_LSB     = 56;
  localparam logic [2:0] DM_EXTERNAL = 3'd7;

  // Only the programmable fields are stored; reserved bits read as zero.
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       invert;
    logic       destMode;
    logic [2:0] mode;
    logic [7:0] vector;
  } entry_t;

  typedef struct packed {
    logic capture;   // latch the lowest eligible pin into the message regs
    logic extLatch;  // replace message vector with the external one
    logic commit;    // message accepted: retire the pin
    logic busy;      // a request is outstanding
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_SEND} ctlState_t;
endpackage

// File: rtl/irqr_datapath.sv
module irqr_datapath
  import irqr_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic                wrHigh,
  input  logic [31:0]         wrData,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [63:0]         rdData,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  input  logic [7:0]          extVector,
  input  ctlStrobe_t          strb,
  output logic                anyEligible,
  output logic                selIsExt,
  output logic [7:0]          msgDest,
  output logic                msgDestMode,
  output logic [2:0]          msgDelivMode,
  output logic [7:0]          msgVector,
  output logic                msgLevel
);
  localparam entry_t RESET_ENTRY = '{mask: 1'b1, default: '0};

  entry_t              tbl [NUM_PINS];
  logic [NUM_PINS-1:0] pending, remoteIrr, prevAct;
  logic [NUM_PINS-1:0] pinRaw, pinAct, rise, eligible;
  logic [IDX_W-1:0]    selIdx, curIdx;

  // Line-to-pin routing and per-pin qualification
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    if (p == 0) begin : g_none
      assign pinRaw[p] = 1'b0;
    end else if (p == 2) begin : g_shared
      assign pinRaw[p] = irqIn[0] | irqIn[2];
    end else begin : g_direct
      assign pinRaw[p] = irqIn[p];
    end
    assign pinAct[p]   = pinRaw[p] ^ tbl[p].invert;
    assign rise[p]     = pinAct[p] & ~prevAct[p];
    assign eligible[p] = pending[p] & ~tbl[p].mask & ~remoteIrr[p];
  end

  // Entry storage and write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PINS; i++) tbl[i] <= RESET_ENTRY;
    end else if (wrEn && int'(wrIdx) < NUM_PINS) begin
      if (wrHigh) begin
        tbl[wrIdx].dest <= wrData[DEST_LSB-32 +: 8];
      end else begin
        tbl[wrIdx].vector   <= wrData[VEC_LSB +: 8];
        tbl[wrIdx].mode     <= wrData[DM_LSB +: 3];
        tbl[wrIdx].destMode <= wrData[DESTMODE_BIT];
        tbl[wrIdx].invert   <= wrData[POL_BIT];
        tbl[wrIdx].level    <= wrData[TRIG_BIT];
        tbl[wrIdx].mask     <= wrData[MASK_BIT];
      end
    end
  end

  // Pending, remote-IRR and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      remoteIrr <= '0;
      prevAct   <= '0;
    end else begin
      prevAct <= pinAct;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (tbl[i].level) begin
          pending[i] <= pinAct[i];
        end else if (rise[i] && !tbl[i].mask) begin
          pending[i] <= 1'b1;
        end else if (strb.commit && int'(curIdx) == i) begin
          pending[i] <= 1'b0;
        end
        if (strb.commit && int'(curIdx) == i && msgLevel) begin
          remoteIrr[i] <= 1'b1;
        end else if (eoiValid && remoteIrr[i] && tbl[i].vector == eoiVector) begin
          remoteIrr[i] <= 1'b0;
        end
      end
    end
  end

  // Lowest-numbered eligible pin
  always_comb begin
    selIdx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (eligible[i]) selIdx = IDX_W'(i);
    end
  end
  assign anyEligible = |eligible;
  assign selIsExt    = (tbl[selIdx].mode == DM_EXTERNAL);

  // Message registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx       <= '0;
      msgDest      <= '0;
      msgDestMode  <= 1'b0;
      msgDelivMode <= '0;
      msgVector    <= '0;
      msgLevel     <= 1'b0;
    end else if (strb.capture) begin
      curIdx       <= selIdx;
      msgDest      <= tbl[selIdx].dest;
      msgDestMode  <= tbl[selIdx].destMode;
      msgDelivMode <= tbl[selIdx].mode;
      msgVector    <= tbl[selIdx].vector;
      msgLevel     <= tbl[selIdx].level;
    end else if (strb.extLatch) begin
      msgVector <= extVector;
    end
  end

  // Entry image for the read port
  always_comb begin
    rdData = '0;
    if (int'(rdIdx) < NUM_PINS) begin
      rdData[VEC_LSB +: 8]   = tbl[rdIdx].vector;
      rdData[DM_LSB +: 3]    = tbl[rdIdx].mode;
      rdData[DESTMODE_BIT]   = tbl[rdIdx].destMode;
      rdData[DSTAT_BIT]      = strb.busy && (curIdx == rdIdx);
      rdData[POL_BIT]        = tbl[rdIdx].invert;
      rdData[RIRR_BIT]       = remoteIrr[rdIdx];
      rdData[TRIG_BIT]       = tbl[rdIdx].level;
      rdData[MASK_BIT]       = tbl[rdIdx].mask;
      rdData[DEST_LSB +: 8]  = tbl[rdIdx].dest;
    end
  end
endmodule

// File: rtl/irqr_control.sv
module irqr_control
  import irqr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyEligible,
  input  logic       selIsExt,
  input  logic       msgReady,
  input  logic       extAckDone,
  output ctlStrobe_t strb,
  output logic       msgValid,
  output logic       extAckReq
);
  ctlState_t state, stateNext;

  always_comb begin
    stateNext     = state;
    strb          = '0;
    strb.busy     = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (anyEligible) begin
          strb.capture = 1'b1;
          stateNext    = selIsExt ? ST_ACK : ST_SEND;
        end
      end
      ST_ACK: begin
        if (extAckDone) begin
          strb.extLatch = 1'b1;
          stateNext     = ST_SEND;
        end
      end
      ST_SEND: begin
        if (msgReady) begin
          strb.commit = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign msgValid  = (state == ST_SEND);
  assign extAckReq = (state == ST_ACK);
endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irqr_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IDX_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic                wrHigh,
  input  logic [31:0]         wrData,
  input  logic [IDX_W-1:0]    rdIdx,
  output logic [63:0]         rdData,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [7:0]          msgDest,
  output logic                msgDestMode,
  output logic [2:0]          msgDelivMode,
  output logic [7:0]          msgVector,
  output logic                msgLevel,
  output logic                extAckReq,
  input  logic                extAckDone,
  input  logic [7:0]          extVector
);
  ctlStrobe_t strb;
  logic       anyEligible, selIsExt;

  irqr_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrHigh(wrHigh), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .extVector(extVector),
    .strb(strb), .anyEligible(anyEligible), .selIsExt(selIsExt),
    .msgDest(msgDest), .msgDestMode(msgDestMode), .msgDelivMode(msgDelivMode),
    .msgVector(msgVector), .msgLevel(msgLevel)
  );

  irqr_control u_ctl (
    .clk(clk), .rstN(rstN), .anyEligible(anyEligible), .selIsExt(selIsExt),
    .msgReady(msgReady), .extAckDone(extAckDone),
    .strb(strb), .msgValid(msgValid), .extAckReq(extAckReq)
  );
endmodule

// File: rtl/irq_redirect_engine_chk.sv
module irq_redirect_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       msgValid,
  input logic       msgReady,
  input logic [7:0] msgDest,
  input logic       msgDestMode,
  input logic [2:0] msgDelivMode,
  input logic [7:0] msgVector,
  input logic       msgLevel,
  input logic       extAckReq,
  input logic       extAckDone,
  input logic [7:0] extVector
);
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid &&
      $stable({msgDest, msgDestMode, msgDelivMode, msgVector, msgLevel})); // R9

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    !(msgValid && extAckReq)); // R9

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    extAckReq && !extAckDone |=> extAckReq); // R8

  AST_EXT_VECTOR_USED: assert property (@(posedge clk) disable iff (!rstN)
    extAckReq && extAckDone |=> msgValid && msgDelivMode == 3'd7 &&
      msgVector == $past(extVector)); // R8

  AST_RETIRE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgReady |=> !msgValid && !extAckReq); // R9
endmodule

bind irq_redirect_engine irq_redirect_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
  .msgDest(msgDest), .msgDestMode(msgDestMode), .msgDelivMode(msgDelivMode),
  .msgVector(msgVector), .msgLevel(msgLevel), .extAckReq(extAckReq),
  .extAckDone(extAckDone), .extVector(extVector)
);

// File: tb/irq_redirect_engine_bench.sv
module irq_redirect_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [NP-1:0] irqIn = '0;
  logic        wrEn = 1'b0, wrHigh = 1'b0;
  logic [4:0]  wrIdx = '0, rdIdx = '0;
  logic [31:0] wrData = '0;
  logic [63:0] rdData;
  logic        eoiValid = 1'b0;
  logic [7:0]  eoiVector = '0;
  logic        msgValid, msgDestMode, msgLevel, extAckReq;
  logic        msgReady = 1'b0, extAckDone = 1'b0;
  logic [7:0]  msgDest, msgVector, extVector = '0;
  logic [2:0]  msgDelivMode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redirect_engine u_irq_redirect_engine (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrHigh(wrHigh), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData),
    .eoiValid(eoiValid), .eoiVector(eoiVector), .msgValid(msgValid),
    .msgReady(msgReady), .msgDest(msgDest), .msgDestMode(msgDestMode),
    .msgDelivMode(msgDelivMode), .msgVector(msgVector), .msgLevel(msgLevel),
    .extAckReq(extAckReq), .extAckDone(extAckDone), .extVector(extVector)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0] mVec [NP];
  bit [2:0] mMode [NP];
  bit [7:0] mDst [NP];
  bit mDm [NP], mPol [NP], mTrig [NP], mMask [NP];
  bit [NP-1:0] mPend, mRem, mPrev;
  int mState, mCur;
  bit [7:0] oDest, oVec;
  bit [2:0] oMode;
  bit oDm, oLvl;

  function automatic bit lineVal(int p);
    if (p == 0) return 1'b0;
    if (p == 2) return irqIn[0] | irqIn[2];
    return irqIn[p];
  endfunction

  always @(posedge clk or negedge rstN) begin
    bit acc, act, found;
    bit [NP-1:0] nPend, nRem, nPrev;
    if (!rstN) begin
      for (int p = 0; p < NP; p++) begin
        mVec[p] = 0; mMode[p] = 0; mDst[p] = 0; mDm[p] = 0;
        mPol[p] = 0; mTrig[p] = 0; mMask[p] = 1;
      end
      mPend = '0; mRem = '0; mPrev = '0; mState = 0; mCur = 0;
      oDest = 0; oVec = 0; oMode = 0; oDm = 0; oLvl = 0;
    end else begin
      acc = (mState == 2) && msgReady;
      nPend = mPend; nRem = mRem;
      for (int p = 0; p < NP; p++) begin
        act = lineVal(p) ^ mPol[p];
        if (mTrig[p]) nPend[p] = act;
        else begin
          if (acc && mCur == p) nPend[p] = 0;
          if (act && !mPrev[p] && !mMask[p]) nPend[p] = 1;
        end
        if (eoiValid && mRem[p] && mVec[p] == eoiVector) nRem[p] = 0;
        if (acc && mCur == p && oLvl) nRem[p] = 1;
        nPrev[p] = act;
      end
      if (mState == 0) begin
        found = 0;
        for (int p = 0; p < NP; p++) begin
          if (!found && mPend[p] && !mMask[p] && !mRem[p]) begin
            found = 1; mCur = p;
            oDest = mDst[p]; oVec = mVec[p]; oMode = mMode[p]; oDm = mDm[p]; oLvl = mTrig[p];
            mState = (mMode[p] == 3'd7) ? 1 : 2;
          end
        end
      end else if (mState == 1) begin
        if (extAckDone) begin oVec = extVector; mState = 2; end
      end else if (msgReady) mState = 0;
      if (wrEn && wrIdx < NP) begin
        if (wrHigh) mDst[wrIdx] = wrData[31:24];
        else begin
          mVec[wrIdx] = wrData[7:0]; mMode[wrIdx] = wrData[10:8]; mDm[wrIdx] = wrData[11];
          mPol[wrIdx] = wrData[13]; mTrig[wrIdx] = wrData[15]; mMask[wrIdx] = wrData[16];
        end
      end
      mPend = nPend; mRem = nRem; mPrev = nPrev;
    end
  end

  // Compare registered outputs against the model every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(msgValid == (mState == 2), "R9 msgValid vs model", msgValid, mState == 2);
      check(extAckReq == (mState == 1), "R8 extAckReq vs model", extAckReq, mState == 1);
      if (msgValid && mState == 2)
        check({msgDest, msgDestMode, msgDelivMode, msgVector, msgLevel} == {oDest, oDm, oMode, oVec, oLvl},
              "R11 message fields vs model",
              {msgDest, msgDestMode, msgDelivMode, msgVector, msgLevel}, {oDest, oDm, oMode, oVec, oLvl});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic writeEntry(input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrIdx = 5'(idx); wrHigh = hi; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic readEntry(input int idx, output logic [63:0] v);
    rdIdx = 5'(idx);
    #1;
    v = rdData;
  endtask

  task automatic setLine(input int idx, input bit v);
    @(negedge clk);
    irqIn[idx] = v;
  endtask

  task automatic sendEoi(input logic [7:0] vec);
    @(negedge clk);
    eoiValid = 1; eoiVector = vec;
    @(negedge clk);
    eoiValid = 0;
  endtask

  task automatic expectMsg(input string tag, input logic [7:0] vec, input logic [7:0] dst,
                           input bit dm, input logic [2:0] mode, input bit lvl);
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      seen = msgValid;
    end
    check(seen, {tag, " message appears"}, seen, 1);
    check({msgDest, msgDestMode, msgDelivMode, msgVector, msgLevel} == {dst, dm, mode, vec, lvl},
          {tag, " message fields"}, {msgDest, msgDestMode, msgDelivMode, msgVector, msgLevel},
          {dst, dm, mode, vec, lvl});
    msgReady = 1;
    @(negedge clk);
    msgReady = 0;
  endtask

  task automatic expectQuiet(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msgValid || extAckReq) bad++;
    end
    check(bad == 0, {tag, " no request"}, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    readEntry(0, v);  check(v == 64'h1_0000, "R1 entry 0 after reset", v, 64'h1_0000);
    readEntry(23, v); check(v == 64'h1_0000, "R1 entry 23 after reset", v, 64'h1_0000);
    check(!msgValid && !extAckReq, "R1 no request after reset", {msgValid, extAckReq}, 0);

    // R5/R11 edge pin 5, delivered once; R6 edge pending cleared
    writeEntry(5, 1, 32'h3C00_0000);
    writeEntry(5, 0, 32'h0000_0841);
    setLine(5, 1);
    expectMsg("R5 R11 edge pin 5", 8'h41, 8'h3C, 1, 3'd0, 0);
    expectQuiet(6, "R6 edge pin retired");
    // R5 masked rise is dropped
    setLine(5, 0);
    writeEntry(5, 0, 32'h0001_0841);
    setLine(5, 1);
    writeEntry(5, 0, 32'h0000_0841);
    expectQuiet(6, "R5 masked rise dropped");

    // R4/R6/R7 level pin 7
    writeEntry(7, 1, 32'h0100_0000);
    writeEntry(7, 0, 32'h0000_8052);
    setLine(7, 1);
    expectMsg("R4 level pin 7", 8'h52, 8'h01, 0, 3'd0, 1);
    expectQuiet(6, "R6 remote IRR blocks level pin");
    readEntry(7, v); check(v[14] == 1'b1, "R6 remote IRR bit set", v[14], 1);
    sendEoi(8'h53);
    expectQuiet(4, "R7 EOI with other vector ignored");
    sendEoi(8'h52);
    expectMsg("R7 redelivery after EOI", 8'h52, 8'h01, 0, 3'd0, 1);
    setLine(7, 0);
    sendEoi(8'h52);
    expectQuiet(6, "R4 R7 inactive level pin not redelivered");
    readEntry(7, v); check(v[14] == 1'b0, "R7 remote IRR cleared", v[14], 0);

    // R3 polarity inversion on level pin 9
    writeEntry(9, 0, 32'h0000_A060);
    expectMsg("R3 inverted low line active", 8'h60, 8'h00, 0, 3'd0, 1);
    setLine(9, 1);
    sendEoi(8'h60);
    expectQuiet(6, "R3 inverted high line inactive");
    writeEntry(9, 0, 32'h0001_0000);

    // R2 line routing
    writeEntry(0, 0, 32'h0000_0020);
    writeEntry(2, 0, 32'h0000_0022);
    setLine(0, 1);
    expectMsg("R2 line 0 reaches pin 2", 8'h22, 8'h00, 0, 3'd0, 0);
    setLine(0, 0);
    expectQuiet(4, "R2 pin 0 has no source");
    setLine(2, 1);
    expectMsg("R2 line 2 reaches pin 2", 8'h22, 8'h00, 0, 3'd0, 0);
    setLine(2, 0);

    // R8/R12 external vector
    writeEntry(4, 0, 32'h0000_0711);
    setLine(4, 1);
    for (int i = 0; i < 20 && !extAckReq; i++) @(negedge clk);
    check(extAckReq, "R8 ack request raised", extAckReq, 1);
    readEntry(4, v); check(v[12] == 1'b1, "R12 status set while outstanding", v[12], 1);
    repeat (2) @(negedge clk);
    check(extAckReq && !msgValid, "R8 ack held without message", {extAckReq, msgValid}, 2'b10);
    extVector = 8'h99; extAckDone = 1;
    @(negedge clk);
    extAckDone = 0;
    expectMsg("R8 external vector used", 8'h99, 8'h00, 0, 3'd7, 0);
    readEntry(4, v); check(v[12] == 1'b0, "R12 status clear after accept", v[12], 0);

    // R9 priority and hold
    writeEntry(10, 0, 32'h0000_0070);
    writeEntry(12, 0, 32'h0000_0072);
    @(negedge clk);
    irqIn[10] = 1; irqIn[12] = 1;
    for (int i = 0; i < 20 && !msgValid; i++) @(negedge clk);
    check(msgVector == 8'h70, "R9 lowest pin first", msgVector, 8'h70);
    repeat (3) @(negedge clk);
    check(msgValid && msgVector == 8'h70, "R9 message held until ready", {msgValid, msgVector}, {1'b1, 8'h70});
    expectMsg("R9 first accepted", 8'h70, 8'h00, 0, 3'd0, 0);
    expectMsg("R9 second pin follows", 8'h72, 8'h00, 0, 3'd0, 0);

    // R10 unmask write delivers pending level pin
    writeEntry(14, 0, 32'h0001_8080);
    setLine(14, 1);
    expectQuiet(5, "R10 masked level pin waits");
    writeEntry(14, 0, 32'h0000_8080);
    expectMsg("R10 delivery after unmask write", 8'h80, 8'h00, 0, 3'd0, 1);
    setLine(14, 0);
    sendEoi(8'h80);

    // R13 write field selection
    writeEntry(15, 0, 32'hFFFF_FFFF);
    writeEntry(15, 1, 32'hFFFF_FFFF);
    readEntry(15, v);
    check(v == 64'hFF00_0000_0001_AFFF, "R13 writable bits only", v, 64'hFF00_0000_0001_AFFF);
    writeEntry(15, 0, 32'h0001_0000);
    expectQuiet(4, "R13 masked entry quiet");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule